// File: doc/BRIEF.md
# SPI-Attached UART Register Bridge

This block is the register side of a serial port that a host controls over SPI. The host lowers chip select, clocks one 16-bit command in most significant bit first, and in the same clocks receives a 16-bit response. The two leading command bits select the operation, and the other fourteen carry a configuration word or a transmit character. Every response opens with two status bits: a received character is waiting, and the transmitter can take a new character.

The bridge holds a 14-bit configuration word and exposes it on a port. The unused control fields go to logic outside the block. From the four-bit rate code, a divider makes a 16x oversampling enable. Transmit characters go out to an external serialiser through a valid/ready pair. Received characters, with their parity and framing-error flag, come in from an external deserialiser through a valid/ready pair into a one-entry holding register. The block samples the SPI pins with its own clock, so the SPI clock must be several times slower than `clk`.

Top module: `spi_uart_bridge`

## Requirements
- R1: A frame is exactly 16 `spi_sclk` rising edges while `spi_cs_n` is low. Command bits are taken MSB first on rising edges. Response bit 15 is on `spi_miso` before the first rising edge, and each later bit is presented after a falling edge, for the host to sample on the next rising edge.
- R2: Command bits 15:14 select the operation: 2'b11 write configuration, 2'b01 read configuration, 2'b10 write data, 2'b00 read data.
- R3: A completed write-configuration frame stores command bits 13:0, which appear on `cfg_word`. A read-configuration response returns the stored word in bits 13:0. Within the word, bit 12 is shutdown and bits 3:0 are the rate code.
- R4: In every response, bit 15 is 1 when the holding register has a character and bit 14 is 1 when `tx_valid` is low. Both bits are sampled when chip select falls.
- R5: Read-data and write-data responses carry the held character in bits 7:0, its parity in bit 8, and the inverse of `cts_n` in bit 9. Bit 10 is `rx_activity` when shutdown (cfg bit 12) is set and the framing-error flag otherwise. Bits 13:11 are 0. A write-configuration response has bits 13:0 at 0.
- R6: `rx_ready` is high exactly while the holding register is empty. A completed read-data frame empties the holding register; write-data frames do not.
- R7: A completed write-data frame raises `tx_valid` with `tx_data` = bits 7:0 and `tx_par` = bit 8 only when `tx_valid` is low and bit 10 is 0. Otherwise the character is dropped. `tx_valid` and its data hold until `tx_ready`.
- R8: Every completed write-data frame sets `rts_n` to the inverse of command bit 9.
- R9: A frame that ends with a count other than 16 rising edges changes no state.
- R10: `baud_tick` pulses once every D clocks. D is 1, 2, 4 for rate codes 0, 1, 2; D is 1 for codes 3 to 8; D is 6, 12, 24, 48, 96, 192, 384 for codes 9 to 15.
- R11: After reset, `cfg_word` is 0, `rts_n` is 1, `tx_valid` is 0, `rx_ready` is 1 and `spi_miso` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; also samples the SPI pins |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sclk | input | 1 | SPI clock from the host |
| spi_cs_n | input | 1 | Frame select, active low |
| spi_mosi | input | 1 | Command bits from the host |
| spi_miso | output | 1 | Response bits to the host |
| baud_tick | output | 1 | 16x oversampling enable |
| cfg_word | output | 14 | Stored configuration word |
| tx_data | output | 8 | Character for the serialiser |
| tx_par | output | 1 | Parity bit for the serialiser |
| tx_valid | output | 1 | Transmit character pending |
| tx_ready | input | 1 | Serialiser takes the character |
| rx_data | input | 8 | Received character |
| rx_par | input | 1 | Received parity bit |
| rx_ferr | input | 1 | Received framing error |
| rx_valid | input | 1 | Received character offered |
| rx_ready | output | 1 | Holding register empty |
| rx_activity | input | 1 | Line activity flag for shutdown mode |
| cts_n | input | 1 | Clear-to-send pin, active low |
| rts_n | output | 1 | Request-to-send pin, active low |

## Verification
The bench keeps the default two-stage pin synchroniser and drives SPI with a half period of eight clocks. This leaves margin for the four-to-five-clock path from a pin edge to `spi_miso`, and it still lets one frame finish in about three hundred clocks. That speed allows several hundred mixed random frames, plus interval checks on rate codes from divide-by-1 up to divide-by-384. The same interval checks cover one code from the 3-to-8 band.

// File: rtl/spi_uart_pkg.sv
// Package: shared frame constants, operation codes and the rate-code divider map.
// Assumes a 16-bit frame with the operation code in the top two bits.
package spi_uart_pkg;

    localparam int FRAME_BITS = 16;
    localparam int CFG_BITS   = 14;
    localparam int CHAR_BITS  = 8;
    localparam int DIV_BITS   = 9;

    // Field positions that other logic decodes.
    localparam int CFG_SHDN_POS = 12;
    localparam int WD_TXOFF_POS = 10;
    localparam int WD_RTS_POS   = 9;
    localparam int PAR_POS      = 8;

    typedef enum logic [1:0] {
        OP_RD_DATA = 2'b00,
        OP_RD_CFG  = 2'b01,
        OP_WR_DATA = 2'b10,
        OP_WR_CFG  = 2'b11
    } op_e;

    // Clock divisor for the oversampling enable, chosen by rate code.
    function automatic logic [DIV_BITS-1:0] rate_divisor(input logic [3:0] code);
        logic [DIV_BITS-1:0] d;
        case (code)
            4'd1:    d = DIV_BITS'(2);
            4'd2:    d = DIV_BITS'(4);
            4'd9:    d = DIV_BITS'(6);
            4'd10:   d = DIV_BITS'(12);
            4'd11:   d = DIV_BITS'(24);
            4'd12:   d = DIV_BITS'(48);
            4'd13:   d = DIV_BITS'(96);
            4'd14:   d = DIV_BITS'(192);
            4'd15:   d = DIV_BITS'(384);
            default: d = DIV_BITS'(1);
        endcase
        return d;
    endfunction

endpackage

// File: rtl/spi_uart_frontend.sv
// SPI frame engine: synchronises the SPI pins into clk, shifts the command in
// on rising edges, steps the response out after falling edges, and flags frame
// start and completed frames. Assumes sclk is several times slower than clk.
module spi_uart_frontend #(
    parameter int SYNC_STAGES = 2,
    parameter int FRAME_BITS  = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  spi_sclk,
    input  logic                  spi_cs_n,
    input  logic                  spi_mosi,
    input  logic [FRAME_BITS-1:0] resp_word,
    output logic                  spi_miso,
    output logic                  frame_start,
    output logic                  frame_done,
    output logic [FRAME_BITS-1:0] frame_word,
    output logic [1:0]            op_bits
);

    localparam int CNT_W = $clog2(FRAME_BITS + 2);
    localparam int IDX_W = $clog2(FRAME_BITS);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_BITS + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);

    logic [SYNC_STAGES-1:0] sclk_s, cs_s, mosi_s;
    logic                   sclk_d, cs_d;
    logic                   sclk_now, cs_now, mosi_now;
    logic                   rise, fall, cs_fall, cs_rise;
    logic [CNT_W-1:0]       rcnt, fcnt;
    logic [FRAME_BITS-1:0]  sh;
    logic [1:0]             op_q;
    logic [IDX_W-1:0]       bit_sel;
    logic                   miso_q;

    // Synchroniser chains for the three SPI inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_s <= '0;
            cs_s   <= '1;
            mosi_s <= '0;
        end else begin
            sclk_s <= {sclk_s[SYNC_STAGES-2:0], spi_sclk};
            cs_s   <= {cs_s[SYNC_STAGES-2:0], spi_cs_n};
            mosi_s <= {mosi_s[SYNC_STAGES-2:0], spi_mosi};
        end
    end

    assign sclk_now = sclk_s[SYNC_STAGES-1];
    assign cs_now   = cs_s[SYNC_STAGES-1];
    assign mosi_now = mosi_s[SYNC_STAGES-1];

    // Delayed copies used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            cs_d   <= 1'b1;
        end else begin
            sclk_d <= sclk_now;
            cs_d   <= cs_now;
        end
    end

    assign rise    = sclk_now & ~sclk_d & ~cs_now;
    assign fall    = ~sclk_now & sclk_d & ~cs_now;
    assign cs_fall = ~cs_now & cs_d;
    assign cs_rise = cs_now & ~cs_d;

    // Command shift register and saturating edge counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh   <= '0;
            rcnt <= '0;
            fcnt <= '0;
            op_q <= 2'b00;
        end else if (cs_fall) begin
            sh   <= '0;
            rcnt <= '0;
            fcnt <= '0;
        end else begin
            if (rise) begin
                sh <= {sh[FRAME_BITS-2:0], mosi_now};
                if (rcnt == CNT_W'(1)) op_q <= {sh[0], mosi_now};
                if (rcnt != CNT_SAT) rcnt <= rcnt + 1'b1;
            end
            if (fall && fcnt != CNT_SAT) fcnt <= fcnt + 1'b1;
        end
    end

    assign bit_sel = IDX_W'(FRAME_BITS - 1) - fcnt[IDX_W-1:0];

    // Response bit register: follows the falling-edge count while selected.
    always_ff @(posedge clk) begin
        if (!rst_n)                miso_q <= 1'b0;
        else if (cs_now)           miso_q <= 1'b0;
        else if (fcnt < CNT_FULL)  miso_q <= resp_word[bit_sel];
        else                       miso_q <= 1'b0;
    end

    assign spi_miso    = miso_q;
    assign frame_start = cs_fall;
    assign frame_done  = cs_rise & (rcnt == CNT_FULL);
    assign frame_word  = sh;
    assign op_bits     = op_q;

endmodule

// File: rtl/spi_uart_baud.sv
// Oversampling enable generator: divides clk by the divisor of the rate code.
// Assumes the rate code is static between configuration writes; a code change
// restarts the count.
module spi_uart_baud #(
    parameter int DIV_W = spi_uart_pkg::DIV_BITS
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] rate_code,
    output logic       tick
);
    import spi_uart_pkg::*;

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] last;
    logic [3:0]       code_q;
    logic             same;

    assign last = DIV_W'(rate_divisor(rate_code)) - 1'b1;
    assign same = (code_q == rate_code);

    // Divider counter, restarted on a code change or at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            code_q <= 4'd0;
        end else begin
            code_q <= rate_code;
            if (!same || cnt >= last) cnt <= '0;
            else                      cnt <= cnt + 1'b1;
        end
    end

    assign tick = same && (cnt == last);

endmodule

// File: rtl/spi_uart_rxhold.sv
// One-entry holding register for received characters. Accepts a character
// while empty and frees on pop. Assumes pop only when full matters.
module spi_uart_rxhold #(
    parameter int W = spi_uart_pkg::CHAR_BITS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] in_data,
    input  logic         in_par,
    input  logic         in_ferr,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic         pop,
    output logic         full,
    output logic [W-1:0] held_data,
    output logic         held_par,
    output logic         held_ferr
);

    // Capture on handshake, release on pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full      <= 1'b0;
            held_data <= '0;
            held_par  <= 1'b0;
            held_ferr <= 1'b0;
        end else if (in_valid && !full) begin
            full      <= 1'b1;
            held_data <= in_data;
            held_par  <= in_par;
            held_ferr <= in_ferr;
        end else if (pop) begin
            full <= 1'b0;
        end
    end

    assign in_ready = ~full;

endmodule

// File: rtl/spi_uart_bridge.sv
// Top: decodes SPI command frames into configuration, transmit and receive
// actions, builds the response word, and drives the rate enable. Assumes the
// external serialiser and deserialiser use the valid/ready pairs.
module spi_uart_bridge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        spi_sclk,
    input  logic        spi_cs_n,
    input  logic        spi_mosi,
    output logic        spi_miso,
    output logic        baud_tick,
    output logic [13:0] cfg_word,
    output logic [7:0]  tx_data,
    output logic        tx_par,
    output logic        tx_valid,
    input  logic        tx_ready,
    input  logic [7:0]  rx_data,
    input  logic        rx_par,
    input  logic        rx_ferr,
    input  logic        rx_valid,
    output logic        rx_ready,
    input  logic        rx_activity,
    input  logic        cts_n,
    output logic        rts_n
);
    import spi_uart_pkg::*;

    localparam int DAT_W = CHAR_BITS + 3;
    localparam int PAD_W = CFG_BITS - DAT_W;

    logic [FRAME_BITS-1:0] resp_word, frame_word;
    logic [1:0]            op_bits;
    logic                  frame_start, frame_done;
    logic                  commit_wc, commit_wd, commit_rd, tx_load;
    logic [CFG_BITS-1:0]   cfg_q;
    logic                  rx_full, h_par, h_ferr;
    logic [CHAR_BITS-1:0]  h_data;
    logic                  snap_avail, snap_free;
    logic [DAT_W-1:0]      snap_dat;
    logic                  rts_q;

    spi_uart_frontend #(
        .SYNC_STAGES (SYNC_STAGES),
        .FRAME_BITS  (FRAME_BITS)
    ) fe_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .spi_sclk    (spi_sclk),
        .spi_cs_n    (spi_cs_n),
        .spi_mosi    (spi_mosi),
        .resp_word   (resp_word),
        .spi_miso    (spi_miso),
        .frame_start (frame_start),
        .frame_done  (frame_done),
        .frame_word  (frame_word),
        .op_bits     (op_bits)
    );

    spi_uart_baud #(.DIV_W(DIV_BITS)) baud_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rate_code (cfg_q[3:0]),
        .tick      (baud_tick)
    );

    spi_uart_rxhold #(.W(CHAR_BITS)) hold_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_data   (rx_data),
        .in_par    (rx_par),
        .in_ferr   (rx_ferr),
        .in_valid  (rx_valid),
        .in_ready  (rx_ready),
        .pop       (commit_rd),
        .full      (rx_full),
        .held_data (h_data),
        .held_par  (h_par),
        .held_ferr (h_ferr)
    );

    assign commit_wc = frame_done && (frame_word[15:14] == OP_WR_CFG);
    assign commit_wd = frame_done && (frame_word[15:14] == OP_WR_DATA);
    assign commit_rd = frame_done && (frame_word[15:14] == OP_RD_DATA);
    assign tx_load   = commit_wd && !tx_valid && !frame_word[WD_TXOFF_POS];

    // Status and receive-field snapshot taken as the frame opens.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_avail <= 1'b0;
            snap_free  <= 1'b1;
            snap_dat   <= '0;
        end else if (frame_start) begin
            snap_avail <= rx_full;
            snap_free  <= ~tx_valid;
            snap_dat   <= {(cfg_q[CFG_SHDN_POS] ? rx_activity : h_ferr), ~cts_n, h_par, h_data};
        end
    end

    // Response word: status bits plus the field set chosen by the operation.
    always_comb begin
        case (op_e'(op_bits))
            OP_RD_CFG:             resp_word = {snap_avail, snap_free, cfg_q};
            OP_RD_DATA, OP_WR_DATA: resp_word = {snap_avail, snap_free, {PAD_W{1'b0}}, snap_dat};
            default:               resp_word = {snap_avail, snap_free, {CFG_BITS{1'b0}}};
        endcase
    end

    // Configuration register.
    always_ff @(posedge clk) begin
        if (!rst_n)         cfg_q <= '0;
        else if (commit_wc) cfg_q <= frame_word[CFG_BITS-1:0];
    end

    // Request-to-send pin, updated by each completed write-data frame.
    always_ff @(posedge clk) begin
        if (!rst_n)         rts_q <= 1'b1;
        else if (commit_wd) rts_q <= ~frame_word[WD_RTS_POS];
    end

    // Transmit holding register towards the serialiser.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_data  <= '0;
            tx_par   <= 1'b0;
        end else if (tx_load) begin
            tx_valid <= 1'b1;
            tx_data  <= frame_word[CHAR_BITS-1:0];
            tx_par   <= frame_word[PAR_POS];
        end else if (tx_valid && tx_ready) begin
            tx_valid <= 1'b0;
        end
    end

    assign cfg_word = cfg_q;
    assign rts_n    = rts_q;

endmodule

// File: rtl/spi_uart_bridge_chk.sv
// Checker for spi_uart_bridge: temporal properties over ports and commit strobes.
module spi_uart_bridge_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [13:0] cfg_word,
    input logic [7:0]  tx_data,
    input logic        tx_par,
    input logic        tx_valid,
    input logic        tx_ready,
    input logic        rx_valid,
    input logic        rx_ready,
    input logic        rts_n,
    input logic        commit_wc,
    input logic        commit_wd,
    input logic        commit_rd
);

    assert_cfg_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_wc |=> $stable(cfg_word));

    assert_tx_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_par));

    assert_tx_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_valid && !commit_wd |=> !tx_valid);

    assert_rts_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_wd |=> $stable(rts_n));

    assert_rx_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && rx_ready |=> !rx_ready);

    assert_rx_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_ready && !commit_rd |=> !rx_ready);

endmodule

bind spi_uart_bridge spi_uart_bridge_chk chk_i (.*);

// File: tb/spi_uart_bridge_tb_top.sv
module spi_uart_bridge_tb_top;

    localparam int H = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
    logic spi_miso, baud_tick, tx_par, tx_valid, rx_ready, rts_n;
    logic [13:0] cfg_word;
    logic [7:0] tx_data;
    logic tx_ready = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic rx_par = 1'b0, rx_ferr = 1'b0, rx_valid = 1'b0, rx_activity = 1'b0, cts_n = 1'b1;

    int checks = 0, fails = 0, cyc = 0;

    // Bench model of the block state
    logic [13:0] m_cfg = '0;
    logic m_full = 1'b0, m_pend = 1'b0, m_rts_n = 1'b1;
    logic [7:0] m_hdat = '0, m_tdat = '0;
    logic m_hpar = 1'b0, m_hferr = 1'b0, m_tpar = 1'b0;

    always #4 clk = ~clk;

    spi_uart_bridge dut_i (
        .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .baud_tick(baud_tick),
        .cfg_word(cfg_word), .tx_data(tx_data), .tx_par(tx_par),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_data(rx_data),
        .rx_par(rx_par), .rx_ferr(rx_ferr), .rx_valid(rx_valid),
        .rx_ready(rx_ready), .rx_activity(rx_activity), .cts_n(cts_n),
        .rts_n(rts_n)
    );

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Expected response from the model state at frame start (R4, R5, R3)
    function automatic logic [15:0] exp_resp(input logic [1:0] op);
        logic [15:0] r;
        r = {m_full, ~m_pend, 14'h0};
        case (op)
            2'b01: r[13:0] = m_cfg;
            2'b00, 2'b10: r[10:0] = {(m_cfg[12] ? rx_activity : m_hferr), ~cts_n, m_hpar, m_hdat};
            default: ;
        endcase
        return r;
    endfunction

    task automatic spi_xfer(input logic [15:0] cmd, input int nbits, output logic [15:0] resp);
        @(negedge clk);
        resp = '0;
        spi_cs_n = 1'b0;
        for (int i = 0; i < nbits; i++) begin
            spi_mosi = (i < 16) ? cmd[15-i] : 1'b0;
            wait_n(H);
            if (i < 16) resp[15-i] = spi_miso;
            spi_sclk = 1'b1;
            wait_n(H);
            spi_sclk = 1'b0;
        end
        wait_n(H);
        spi_cs_n = 1'b1;
        wait_n(2*H);
    endtask

    // Complete frame with response check and model update (R1, R2)
    task automatic frame(input logic [15:0] cmd, input string req);
        logic [15:0] exp, got;
        exp = exp_resp(cmd[15:14]);
        spi_xfer(cmd, 16, got);
        chk(req, {16'h0, got}, {16'h0, exp});
        case (cmd[15:14])
            2'b11: m_cfg = cmd[13:0];
            2'b10: begin
                m_rts_n = ~cmd[9];
                if (!m_pend && !cmd[10]) begin
                    m_pend = 1'b1; m_tdat = cmd[7:0]; m_tpar = cmd[8];
                end
            end
            2'b00: m_full = 1'b0;
            default: ;
        endcase
        chk({req, " state"}, {12'h0, m_cfg, m_rts_n, m_pend, ~m_full},
            {12'h0, cfg_word, rts_n, tx_valid, rx_ready});
    endtask

    task automatic offer_rx(input logic [7:0] d, input logic p, input logic f);
        @(negedge clk);
        chk("R6 ready when empty", {31'h0, rx_ready}, 32'h1);
        rx_valid = 1'b1; rx_data = d; rx_par = p; rx_ferr = f;
        @(negedge clk);
        rx_valid = 1'b0;
        m_full = 1'b1; m_hdat = d; m_hpar = p; m_hferr = f;
        chk("R6 ready drops when full", {31'h0, rx_ready}, 32'h0);
    endtask

    task automatic drain_tx();
        @(negedge clk);
        chk("R7 tx pending", {31'h0, tx_valid}, {31'h0, m_pend});
        if (m_pend) begin
            chk("R7 tx fields", {23'h0, tx_par, tx_data}, {23'h0, m_tpar, m_tdat});
            tx_ready = 1'b1;
            @(negedge clk);
            tx_ready = 1'b0;
            m_pend = 1'b0;
        end
    endtask

    function automatic int divisor(input int code);
        case (code)
            1: return 2;  2: return 4;  9: return 6;  10: return 12; 11: return 24;
            12: return 48; 13: return 96; 14: return 192; 15: return 384;
            default: return 1;
        endcase
    endfunction

    task automatic measure_rate(input logic [3:0] code);
        int n;
        frame({2'b11, 10'h0, code}, "R2 wcfg for rate");
        wait_n(4);
        while (!baud_tick) @(negedge clk);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!baud_tick && n < 1000);
        chk($sformatf("R10 divisor code %0d", code), n, divisor(code));
    endtask

    initial begin
        logic [15:0] r;
        void'($urandom(32'h1D0C_5EED));
        wait_n(4);
        rst_n = 1'b1;
        wait_n(2);
        // R11 reset state
        chk("R11 reset", {27'h0, cfg_word == 14'h0, rts_n, tx_valid, rx_ready, spi_miso},
            {27'h0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0});

        // R3 write and read back configuration
        frame(16'hC000 | 16'h2A5B, "R3 write cfg");
        frame(16'h4000, "R3 read cfg");

        // R9 aborted write-config frames: short and long
        spi_xfer(16'hC123, 10, r);
        chk("R9 short frame cfg unchanged", {18'h0, cfg_word}, {18'h0, m_cfg});
        spi_xfer(16'hC321, 17, r);
        chk("R9 long frame cfg unchanged", {18'h0, cfg_word}, {18'h0, m_cfg});

        // R5 framing error vs activity, with shutdown off then on
        frame(16'hC000, "R3 cfg clear");
        offer_rx(8'h5A, 1'b1, 1'b1);
        rx_activity = 1'b0; cts_n = 1'b0;
        frame(16'h8000 | 16'h0400, "R5 wdata response, no pop");
        frame(16'hC000 | 16'h1000, "R3 shutdown on");
        rx_activity = 1'b0;
        // R9 aborted read-data keeps the character
        spi_xfer(16'h0000, 12, r);
        chk("R9 aborted read keeps char", {31'h0, rx_ready}, 32'h0);
        frame(16'h0000, "R5 read data in shutdown, pop R6");
        frame(16'h0000, "R4 empty after pop");

        // R7 transmit gating, R8 rts
        frame(16'h8000 | 16'h0600 | 16'h0033, "R7 te high drops");
        frame(16'h8000 | 16'h0300 | 16'h00C4, "R7 load R8 rts");
        frame(16'h8000 | 16'h0011, "R7 busy drop R8 rts");
        drain_tx();
        frame(16'h4000, "R4 free after drain");

        // R10 rate divisors
        measure_rate(4'd0);
        measure_rate(4'd1);
        measure_rate(4'd2);
        measure_rate(4'd5);
        measure_rate(4'd9);
        measure_rate(4'd12);
        measure_rate(4'd15);

        // Random mix
        for (int k = 0; k < 300; k++) begin
            logic [15:0] cmd;
            cmd = 16'($urandom);
            cts_n = 1'($urandom);
            rx_activity = 1'($urandom);
            if (!m_full && ($urandom % 2 == 0))
                offer_rx(8'($urandom), 1'($urandom), 1'($urandom));
            if ($urandom % 3 == 0) drain_tx();
            if ($urandom % 5 == 0) cmd[10] = 1'b0;
            frame(cmd, "R1 R2 R4 R5 random frame");
        end

        summary();
        $finish;
    end

endmodule